// File: doc/BRIEF.md
# Test-Port Debug Register and Memory Bridge

This block is a test access port with a 4-bit instruction register. It gives an external host two paths into the chip. The first path reaches a small debug register file through a request/acknowledge port. The second is a single-beat Wishbone master, so that firmware can be streamed into memory one 64-bit word per scan. The host sets a target address with one instruction. Data scans then read or write at that address. Both data instructions for a target capture the target's current contents at the start of the scan, so every write scan also returns the value it replaces.

The port pins TCK, TMS and TDI are sampled with the system clock `clk`, and all state lives in that one clock domain. TCK rising edges drive the state machine, capture and shift. Falling edges update TDO. Bus transfers are launched when the machine enters Capture-DR (reads) and when it leaves Update-DR (writes). The bridge assumes that every bus transfer completes within one TCK period. Boundary-scan cells are not part of the block: their instruction codes select the bypass bit.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: Five TCK rising edges with TMS high bring the state machine to Test-Logic-Reset from any state. That state loads instruction 1, and a 32-bit data scan under instruction 1 shifts out 0x000018FF, least significant bit first.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 0b0001, and the new code takes effect on leaving Update-IR.
- R3: Codes 0, 2, 15 and every code other than 1, 5, 6, 7, 8, 9 and 10 select a 1-bit bypass register. It captures 0, so TDO repeats TDI one bit later.
- R4: Code 8 selects an 8-bit debug address register. Capture returns the current address. On leaving Update-DR the shifted value becomes the address driven on `dmi_addr`.
- R5: Code 9 issues a debug-register read at `dmi_addr` on entering Capture-DR. The 64-bit result is shifted out in that same scan, and no write request is made.
- R6: Code 10 shifts out the old 64-bit value of the addressed debug register. On leaving Update-DR it writes the 64 bits shifted in, so a later code-9 scan returns them (for example, writing 5 reads back as 5).
- R7: Code 5 selects a 64-bit Wishbone word-address register. Capture returns the current address, which reflects every increment made so far. Update loads the shifted value.
- R8: Code 6 reads the word at `wb_adr` on entering Capture-DR and shifts it out in that scan. The address then advances by one.
- R9: Code 7 shifts out the word at `wb_adr` without advancing. On leaving Update-DR it writes the shifted-in word there and then advances by one, so consecutive scans fill consecutive words.
- R10: A Wishbone transfer keeps `wb_cyc`/`wb_stb`, `wb_we`, `wb_adr` and `wb_dat_o` steady until `wb_ack`. The cycle ends on the clock after the acknowledge.
- R11: A debug request keeps `dmi_req`, `dmi_we`, `dmi_addr` and `dmi_wdata` steady until `dmi_ack`. The request drops on the clock after the acknowledge.
- R12: TDO changes only after a TCK falling edge, and it is 0 outside the two shift states.
- R13: A low `rst_n` on a rising `clk` edge gives Test-Logic-Reset with instruction 1, both addresses zero, no bus activity and TDO at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; TCK, TMS and TDI are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| tck | input | 1 | Test clock, slower than `clk` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| dmi_req | output | 1 | Debug register request |
| dmi_we | output | 1 | Debug request is a write |
| dmi_addr | output | 8 | Debug register address |
| dmi_wdata | output | 64 | Debug write data |
| dmi_ack | input | 1 | Debug request done |
| dmi_rdata | input | 64 | Debug read data, valid with `dmi_ack` |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 64 | Wishbone word address |
| wb_dat_o | output | 64 | Wishbone write data |
| wb_dat_i | input | 64 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
The assertions watch every clock for the bus handshakes. Both ports must hold their request fields steady until acknowledged and release within one clock after it. TDO may move only after a TCK falling edge. Instruction decoding, the capture values, read-before-write ordering, and the address advancing only on completed transfers can be seen only by whole scans. The bench sweeps every instruction code and every modelled debug register. It streams a run of Wishbone words with varying bus latency and compares each shifted-out value with ones it computes itself.

// File: rtl/jtag_dbg_pkg.sv
// Shared definitions for the test-port bridge: TAP states, instruction
// codes and data-register selection. Assumes a 4-bit instruction register.
package jtag_dbg_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'd0;
    localparam logic [IR_W-1:0] OP_IDENT   = 4'd1;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'd2;
    localparam logic [IR_W-1:0] OP_WB_ADR  = 4'd5;
    localparam logic [IR_W-1:0] OP_WB_RD   = 4'd6;
    localparam logic [IR_W-1:0] OP_WB_WR   = 4'd7;
    localparam logic [IR_W-1:0] OP_DMI_ADR = 4'd8;
    localparam logic [IR_W-1:0] OP_DMI_RD  = 4'd9;
    localparam logic [IR_W-1:0] OP_DMI_WR  = 4'd10;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'd15;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [2:0] {
        SEL_BYPASS, SEL_IDENT, SEL_DMI_ADR, SEL_DMI_DATA, SEL_WB_ADR, SEL_WB_DATA
    } dr_sel_e;

    // Map an instruction code to the data register it places between TDI and TDO.
    function automatic dr_sel_e op_to_sel(input logic [IR_W-1:0] op);
        case (op)
            OP_IDENT:             return SEL_IDENT;
            OP_DMI_ADR:           return SEL_DMI_ADR;
            OP_DMI_RD, OP_DMI_WR: return SEL_DMI_DATA;
            OP_WB_ADR:            return SEL_WB_ADR;
            OP_WB_RD, OP_WB_WR:   return SEL_WB_DATA;
            OP_EXTEST, OP_SAMPLE, OP_BYPASS: return SEL_BYPASS;
            default:              return SEL_BYPASS;
        endcase
    endfunction

    // Larger of two widths.
    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
// Sixteen-state test access port controller. It advances one state per
// qualified TCK rising edge (step) and exposes the state about to be entered.
// Assumes step is a single-clk pulse.
module jtag_tap_fsm
    import jtag_dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e nxt
);

    // Next-state selection from the current state and TMS.
    always_comb begin
        case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    // State register, advanced once per TCK rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= TS_RESET;
        else if (step) state <= nxt;
    end

endmodule

// File: rtl/jtag_dr_path.sv
// Instruction register, shared data shift register and TDO driver.
// Capture values come from the owner of each register. Shifting is LSB
// first, with TDI entering at the top bit of the selected length.
// Assumes tck_rise and tck_fall are single-clk pulses that never coincide.
module jtag_dr_path
    import jtag_dbg_pkg::*;
#(
    parameter int          DR_W      = 64,
    parameter int          DMI_ADR_W = 8,
    parameter int          DATA_W    = 64,
    parameter int          WB_ADR_W  = 64,
    parameter logic [31:0] IDCODE    = 32'h0000_18FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_rise,
    input  logic             tck_fall,
    input  logic             tdi,
    input  tap_state_e       state,
    input  logic [DR_W-1:0]  cap_dmi_adr,
    input  logic [DR_W-1:0]  cap_dmi_data,
    input  logic [DR_W-1:0]  cap_wb_adr,
    input  logic [DR_W-1:0]  cap_wb_data,
    output logic [IR_W-1:0]  ir,
    output logic [DR_W-1:0]  dr,
    output logic             tdo
);

    logic [IR_W-1:0] ir_sr;
    logic [DR_W-1:0] cap_val;
    logic [DR_W-1:0] shifted;
    dr_sel_e         sel;
    int              dr_len;

    assign sel = op_to_sel(ir);

    // Length and capture value of the register the instruction selects.
    always_comb begin
        case (sel)
            SEL_IDENT:    begin dr_len = 32;        cap_val = DR_W'(IDCODE); end
            SEL_DMI_ADR:  begin dr_len = DMI_ADR_W; cap_val = cap_dmi_adr;   end
            SEL_DMI_DATA: begin dr_len = DATA_W;    cap_val = cap_dmi_data;  end
            SEL_WB_ADR:   begin dr_len = WB_ADR_W;  cap_val = cap_wb_adr;    end
            SEL_WB_DATA:  begin dr_len = DATA_W;    cap_val = cap_wb_data;   end
            default:      begin dr_len = 1;         cap_val = '0;            end
        endcase
    end

    // One shift step: move right, insert TDI at the top of the active length.
    always_comb begin
        shifted = {1'b0, dr[DR_W-1:1]};
        for (int i = 0; i < DR_W; i++) begin
            if (i == dr_len - 1) shifted[i] = tdi;
        end
    end

    // Instruction register: reset to ident, capture, shift, update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir    <= OP_IDENT;
            ir_sr <= '0;
        end else if (state == TS_RESET) begin
            ir <= OP_IDENT;
        end else if (tck_rise) begin
            case (state)
                TS_CAP_IR: ir_sr <= IR_CAPTURE;
                TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                TS_UPD_IR: ir    <= ir_sr;
                default:   ;
            endcase
        end
    end

    // Data shift register: capture and shift on TCK rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr <= '0;
        end else if (tck_rise) begin
            if (state == TS_CAP_DR)     dr <= cap_val;
            else if (state == TS_SH_DR) dr <= shifted;
        end
    end

    // TDO: present the outgoing bit after each TCK falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdo <= 1'b0;
        end else if (tck_fall) begin
            case (state)
                TS_SH_DR: tdo <= dr[0];
                TS_SH_IR: tdo <= ir_sr[0];
                default:  tdo <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/jtag_dmi_port.sv
// Request/acknowledge port to the debug register file. It holds the
// register address and runs one read or write at a time. The request is
// held until acknowledged, and read data is kept for the next capture.
// Starts that arrive while a request is open are ignored.
module jtag_dmi_port #(
    parameter int ADR_W  = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adr_load,
    input  logic [ADR_W-1:0]  adr_in,
    input  logic              rd_start,
    input  logic              wr_start,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              dmi_req,
    output logic              dmi_we,
    output logic [ADR_W-1:0]  dmi_addr,
    output logic [DATA_W-1:0] dmi_wdata,
    input  logic              dmi_ack,
    input  logic [DATA_W-1:0] dmi_rdata,
    output logic [DATA_W-1:0] rdata_q
);

    // Address register and request sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmi_req   <= 1'b0;
            dmi_we    <= 1'b0;
            dmi_addr  <= '0;
            dmi_wdata <= '0;
            rdata_q   <= '0;
        end else if (!dmi_req) begin
            if (adr_load) begin
                dmi_addr <= adr_in;
            end else if (rd_start) begin
                dmi_req <= 1'b1;
                dmi_we  <= 1'b0;
            end else if (wr_start) begin
                dmi_req   <= 1'b1;
                dmi_we    <= 1'b1;
                dmi_wdata <= wdata_in;
            end
        end else if (dmi_ack) begin
            dmi_req <= 1'b0;
            if (!dmi_we) rdata_q <= dmi_rdata;
        end
    end

endmodule

// File: rtl/jtag_wb_master.sv
// Single-beat Wishbone master with an auto-advancing word address.
// A read advances the address only when asked to (bump). A write always
// advances it once the acknowledge arrives. Starts while busy are ignored.
module jtag_wb_master #(
    parameter int ADR_W  = 64,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adr_load,
    input  logic [ADR_W-1:0]  adr_in,
    input  logic              rd_start,
    input  logic              rd_bump,
    input  logic              wr_start,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADR_W-1:0]  wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack,
    output logic [DATA_W-1:0] rdata_q
);

    logic bump_q;

    assign wb_stb = wb_cyc;

    // Cycle control, address advance and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_cyc   <= 1'b0;
            wb_we    <= 1'b0;
            wb_adr   <= '0;
            wb_dat_o <= '0;
            rdata_q  <= '0;
            bump_q   <= 1'b0;
        end else if (!wb_cyc) begin
            if (adr_load) begin
                wb_adr <= adr_in;
            end else if (rd_start) begin
                wb_cyc <= 1'b1;
                wb_we  <= 1'b0;
                bump_q <= rd_bump;
            end else if (wr_start) begin
                wb_cyc   <= 1'b1;
                wb_we    <= 1'b1;
                wb_dat_o <= wdata_in;
                bump_q   <= 1'b1;
            end
        end else if (wb_ack) begin
            wb_cyc <= 1'b0;
            if (!wb_we) rdata_q <= wb_dat_i;
            if (bump_q) wb_adr <= wb_adr + ADR_W'(1);
        end
    end

endmodule

// File: rtl/jtag_dbg_bridge.sv
// Top of the test-port bridge. It samples TCK on clk to find its edges,
// then runs the TAP controller, the shift path and the two bus ports.
// Reads are launched on entry to Capture-DR and writes on leaving Update-DR.
// Assumes TCK, TMS and TDI are already synchronous to clk and that every
// bus transfer finishes within one TCK period.
module jtag_dbg_bridge
    import jtag_dbg_pkg::*;
#(
    parameter int          DMI_ADR_W = 8,
    parameter int          DATA_W    = 64,
    parameter int          WB_ADR_W  = 64,
    parameter logic [31:0] IDCODE    = 32'h0000_18FF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tck,
    input  logic                 tms,
    input  logic                 tdi,
    output logic                 tdo,
    output logic                 dmi_req,
    output logic                 dmi_we,
    output logic [DMI_ADR_W-1:0] dmi_addr,
    output logic [DATA_W-1:0]    dmi_wdata,
    input  logic                 dmi_ack,
    input  logic [DATA_W-1:0]    dmi_rdata,
    output logic                 wb_cyc,
    output logic                 wb_stb,
    output logic                 wb_we,
    output logic [WB_ADR_W-1:0]  wb_adr,
    output logic [DATA_W-1:0]    wb_dat_o,
    input  logic [DATA_W-1:0]    wb_dat_i,
    input  logic                 wb_ack
);

    localparam int DR_W = max_w(max_w(DATA_W, WB_ADR_W), max_w(32, DMI_ADR_W));

    logic             tck_q, tck_rise, tck_fall;
    tap_state_e       state, nxt;
    logic [IR_W-1:0]  ir;
    logic [DR_W-1:0]  dr;
    dr_sel_e          sel;
    logic             rd_launch, wr_launch;
    logic [DATA_W-1:0] dmi_rdata_q, wb_rdata_q;

    // TCK edge detection on the system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) tck_q <= 1'b0;
        else        tck_q <= tck;
    end
    assign tck_rise = tck & ~tck_q;
    assign tck_fall = ~tck & tck_q;

    assign sel       = op_to_sel(ir);
    assign rd_launch = tck_rise && (state == TS_SEL_DR) && !tms;
    assign wr_launch = tck_rise && (state == TS_UPD_DR);

    jtag_tap_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (tck_rise),
        .tms   (tms),
        .state (state),
        .nxt   (nxt)
    );

    jtag_dr_path #(
        .DR_W      (DR_W),
        .DMI_ADR_W (DMI_ADR_W),
        .DATA_W    (DATA_W),
        .WB_ADR_W  (WB_ADR_W),
        .IDCODE    (IDCODE)
    ) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .tck_rise     (tck_rise),
        .tck_fall     (tck_fall),
        .tdi          (tdi),
        .state        (state),
        .cap_dmi_adr  (DR_W'(dmi_addr)),
        .cap_dmi_data (DR_W'(dmi_rdata_q)),
        .cap_wb_adr   (DR_W'(wb_adr)),
        .cap_wb_data  (DR_W'(wb_rdata_q)),
        .ir           (ir),
        .dr           (dr),
        .tdo          (tdo)
    );

    jtag_dmi_port #(
        .ADR_W  (DMI_ADR_W),
        .DATA_W (DATA_W)
    ) u_dmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .adr_load  (wr_launch && sel == SEL_DMI_ADR),
        .adr_in    (dr[DMI_ADR_W-1:0]),
        .rd_start  (rd_launch && sel == SEL_DMI_DATA),
        .wr_start  (wr_launch && ir == OP_DMI_WR),
        .wdata_in  (dr[DATA_W-1:0]),
        .dmi_req   (dmi_req),
        .dmi_we    (dmi_we),
        .dmi_addr  (dmi_addr),
        .dmi_wdata (dmi_wdata),
        .dmi_ack   (dmi_ack),
        .dmi_rdata (dmi_rdata),
        .rdata_q   (dmi_rdata_q)
    );

    jtag_wb_master #(
        .ADR_W  (WB_ADR_W),
        .DATA_W (DATA_W)
    ) u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .adr_load (wr_launch && sel == SEL_WB_ADR),
        .adr_in   (dr[WB_ADR_W-1:0]),
        .rd_start (rd_launch && sel == SEL_WB_DATA),
        .rd_bump  (ir == OP_WB_RD),
        .wr_start (wr_launch && ir == OP_WB_WR),
        .wdata_in (dr[DATA_W-1:0]),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_o (wb_dat_o),
        .wb_dat_i (wb_dat_i),
        .wb_ack   (wb_ack),
        .rdata_q  (wb_rdata_q)
    );

endmodule

// File: rtl/jtag_dbg_bridge_checker.sv
// Protocol checker for the bridge: bus handshake stability and TDO timing.
// It is attached to every instance of the top by the bind below.
module jtag_dbg_bridge_checker #(
    parameter int DMI_ADR_W = 8,
    parameter int DATA_W    = 64,
    parameter int WB_ADR_W  = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tck,
    input logic                 tdo,
    input logic                 wb_cyc,
    input logic                 wb_ack,
    input logic                 wb_we,
    input logic [WB_ADR_W-1:0]  wb_adr,
    input logic [DATA_W-1:0]    wb_dat_o,
    input logic                 dmi_req,
    input logic                 dmi_ack,
    input logic                 dmi_we,
    input logic [DMI_ADR_W-1:0] dmi_addr,
    input logic [DATA_W-1:0]    dmi_wdata
);

    // R10: an open Wishbone cycle keeps its fields until acknowledged.
    a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && !wb_ack |=> wb_cyc && $stable(wb_we) && $stable(wb_adr) && $stable(wb_dat_o));

    // R10: single beat, the cycle closes after the acknowledge.
    a_r10_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && wb_ack |=> !wb_cyc);

    // R11: an open debug request keeps its fields until acknowledged.
    a_r11_dmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dmi_req && !dmi_ack |=> dmi_req && $stable(dmi_we) && $stable(dmi_addr) && $stable(dmi_wdata));

    // R11: the request drops after the acknowledge.
    a_r11_dmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        dmi_req && dmi_ack |=> !dmi_req);

    // R12: TDO moves only on the clock that sees a TCK falling edge.
    a_r12_tdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdo) |-> !$past(tck) && $past(tck, 2));

endmodule

bind jtag_dbg_bridge jtag_dbg_bridge_checker #(
    .DMI_ADR_W (DMI_ADR_W),
    .DATA_W    (DATA_W),
    .WB_ADR_W  (WB_ADR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tck       (tck),
    .tdo       (tdo),
    .wb_cyc    (wb_cyc),
    .wb_ack    (wb_ack),
    .wb_we     (wb_we),
    .wb_adr    (wb_adr),
    .wb_dat_o  (wb_dat_o),
    .dmi_req   (dmi_req),
    .dmi_ack   (dmi_ack),
    .dmi_we    (dmi_we),
    .dmi_addr  (dmi_addr),
    .dmi_wdata (dmi_wdata)
);

// File: tb/jtag_dbg_bridge_test.sv
`timescale 1ns/1ps
module jtag_dbg_bridge_test;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        tdo;
    logic        dmi_req, dmi_we, dmi_ack = 1'b0;
    logic [7:0]  dmi_addr;
    logic [63:0] dmi_wdata, dmi_rdata = '0;
    logic        wb_cyc, wb_stb, wb_we, wb_ack = 1'b0;
    logic [63:0] wb_adr, wb_dat_o, wb_dat_i = '0;

    int n_chk = 0, n_fail = 0, lat = 1;
    int wb_wr_n = 0, wb_rd_n = 0, dmi_wr_n = 0;
    bit done = 0;
    logic [63:0] mem [16];
    logic [63:0] dreg [16];

    always #4 clk = ~clk;

    jtag_dbg_bridge uut (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .dmi_req(dmi_req), .dmi_we(dmi_we), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata),
        .dmi_ack(dmi_ack), .dmi_rdata(dmi_rdata),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
    );

    function automatic logic [63:0] mem_init(input int i);
        return 64'hC0DE_0000_0000_0000 + 64'(i) * 64'h0101;
    endfunction
    function automatic logic [63:0] dreg_init(input int i);
        return 64'h0BAD_F00D_0000_0000 ^ (64'(i) << 8) ^ 64'(i * 3);
    endfunction
    function automatic logic [63:0] wvec(input int k);
        return 64'h1234_5678_0000_0000 | (64'(k) << 12) | 64'(~k & 15);
    endfunction

    // Wishbone memory model with programmable acknowledge latency.
    initial begin
        int cnt = 0;
        for (int i = 0; i < 16; i++) mem[i] = mem_init(i);
        forever begin
            @(negedge clk);
            if (wb_ack) begin
                wb_ack = 1'b0;
            end else if (wb_cyc && wb_stb) begin
                cnt++;
                if (cnt >= lat) begin
                    cnt = 0;
                    wb_ack = 1'b1;
                    wb_dat_i = mem[wb_adr[3:0]];
                    if (wb_we) begin mem[wb_adr[3:0]] = wb_dat_o; wb_wr_n++; end
                    else wb_rd_n++;
                end
            end
        end
    end

    // Debug register file model.
    initial begin
        int cnt = 0;
        for (int i = 0; i < 16; i++) dreg[i] = dreg_init(i);
        forever begin
            @(negedge clk);
            if (dmi_ack) begin
                dmi_ack = 1'b0;
            end else if (dmi_req) begin
                cnt++;
                if (cnt >= lat) begin
                    cnt = 0;
                    dmi_ack = 1'b1;
                    dmi_rdata = dreg[dmi_addr[3:0]];
                    if (dmi_we) begin dreg[dmi_addr[3:0]] = dmi_wdata; dmi_wr_n++; end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One TCK period: sample TDO, drive TMS/TDI, raise then lower TCK.
    task automatic tick(input logic m, input logic d, output logic o);
        repeat (2) @(negedge clk);
        o = tdo; tms = m; tdi = d;
        repeat (2) @(negedge clk);
        tck = 1'b1;
        repeat (4) @(negedge clk);
        tck = 1'b0;
    endtask

    task automatic tap_reset();
        logic o;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 4; i++) begin tick(i == 3, code[i], o); cap[i] = o; end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < n; i++) begin tick(i == n - 1, din[i], o); dout[i] = o; end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0]  icap;
        logic [63:0] r;
        logic        o;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R13: reset state at the ports.
        chk("R13 tdo", 64'(tdo), 0);
        chk("R13 wb_cyc", 64'(wb_cyc), 0);
        chk("R13 dmi_req", 64'(dmi_req), 0);
        chk("R13 wb_adr", wb_adr, 0);
        chk("R13 dmi_addr", 64'(dmi_addr), 0);
        tick(0, 0, o);
        // R13/R1: ident selected straight after rst_n.
        scan_dr(32, '1, r); chk("R13 ident after rst_n", r, 64'h18FF);

        // R2: IR capture pattern.
        scan_ir(4'd15, icap); chk("R2 ir capture", 64'(icap), 64'b0001);
        scan_ir(4'd1, icap); chk("R2 ir capture again", 64'(icap), 64'b0001);
        scan_dr(32, 0, r); chk("R1 ident code 1", r, 64'h18FF);

        // R3: every code that is not a data instruction is a 1-bit bypass.
        for (int c = 0; c < 16; c++) begin
            if (!(c == 1 || (c >= 5 && c <= 10))) begin
                logic [63:0] din;
                din = 64'(8'hB4 ^ 8'(c * 17));
                scan_ir(4'(c), icap);
                scan_dr(8, din, r);
                chk($sformatf("R3 bypass code %0d", c), r, {56'b0, din[6:0], 1'b0});
                chk("R12 tdo idle", 64'(tdo), 0);
            end
        end

        // R1: TAP reset from the middle of a shift.
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o); tick(0, 1, o); tick(0, 1, o);
        tap_reset();
        scan_dr(32, 0, r); chk("R1 ident after tms reset", r, 64'h18FF);

        // R4: debug address register.
        scan_ir(4'd8, icap);
        scan_dr(8, 64'h03, r); chk("R4 addr capture initial", r, 0);
        chk("R4 dmi_addr driven", 64'(dmi_addr), 3);
        scan_dr(8, 64'h07, r); chk("R4 addr capture previous", r, 3);

        // R5: read every modelled debug register.
        for (int a = 0; a < 16; a++) begin
            lat = 1 + a % 3;
            scan_ir(4'd8, icap); scan_dr(8, 64'(a), r);
            scan_ir(4'd9, icap); scan_dr(64, '1, r);
            chk($sformatf("R5 dmi read %0d", a), r, dreg_init(a));
        end
        chk("R5 no dmi writes", 64'(dmi_wr_n), 0);

        // R6: write-read returns the old value, then reads return the new.
        for (int a = 0; a < 16; a++) begin
            logic [63:0] nv;
            nv = (a == 0) ? 64'd5 : ~dreg_init(a);
            lat = 3 - a % 3;
            scan_ir(4'd8, icap); scan_dr(8, 64'(a), r);
            scan_ir(4'd10, icap); scan_dr(64, nv, r);
            chk($sformatf("R6 dmi old %0d", a), r, dreg_init(a));
            scan_ir(4'd9, icap); scan_dr(64, 0, r);
            chk($sformatf("R6 dmi new %0d", a), r, nv);
        end
        chk("R6 dmi write count", 64'(dmi_wr_n), 16);

        // R7: address capture from reset, then load 2.
        scan_ir(4'd5, icap); scan_dr(64, 64'd2, r); chk("R7 wb adr capture", r, 0);
        chk("R7 wb_adr loaded", wb_adr, 2);

        // R9: stream eight words with write-read scans.
        scan_ir(4'd7, icap);
        for (int k = 0; k < 8; k++) begin
            lat = 1 + k % 3;
            scan_dr(64, wvec(k), r);
            chk($sformatf("R9 wb old word %0d", k), r, mem_init(2 + k));
        end
        chk("R9 wb_adr advanced", wb_adr, 10);
        chk("R9 wb write count", 64'(wb_wr_n), 8);

        // R7: capture shows the advanced address; reload 2.
        scan_ir(4'd5, icap); scan_dr(64, 64'd2, r); chk("R7 wb adr after stream", r, 10);

        // R8: read back the stream in order.
        scan_ir(4'd6, icap);
        for (int k = 0; k < 8; k++) begin
            lat = 3 - k % 3;
            scan_dr(64, 0, r);
            chk($sformatf("R8 wb read %0d", k), r, wvec(k));
        end
        chk("R8 wb_adr advanced", wb_adr, 10);
        chk("R8 reads do not write", 64'(wb_wr_n), 8);
        chk("R10 wb bus idle", 64'(wb_cyc), 0);
        chk("R11 dmi bus idle", 64'(dmi_req), 0);

        // R13: mid-run reset clears addresses and restores ident.
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R13 wb_adr cleared", wb_adr, 0);
        chk("R13 dmi_addr cleared", 64'(dmi_addr), 0);
        tick(0, 0, o);
        scan_dr(32, 0, r); chk("R13 ident after second reset", r, 64'h18FF);

        done = 1;
        summary();
        $finish;
    end

endmodule